// File: doc/BRIEF.md
# Program flow and skip controller

This block sequences the program counter of a small core whose instructions are 16 bits wide and whose data path is 8 bits wide. On every cycle it looks at the instruction word in the execute stage and decodes the instructions that change program flow: the short branch, the short call, the long call, the three returns and the three conditional skips. For each one it works out the next program counter and whether the instruction needs a second cycle. It also decides whether the word that was already prefetched must be discarded and run as a no-operation.

Two-cycle instructions raise a stall request in the cycle they execute. The cycle after that is a no-operation slot, in which the incoming word is ignored. Calls save their return address on an internal 16-entry return stack, and returns recover it. The block tells the surrounding core when a push or a pop happens, when a return from interrupt must re-enable interrupts, and when a return must load its literal into the working register. The upper bits of every jump target come from an 8-bit high-address latch that the core supplies.

Top module: `flowSeq`

## Requirements
- R1: While reset is low, the program counter is 0x0000, the return-stack pointer is 0 and no no-operation slot is pending. Right after reset is released, with a non-flow word at the input, `pcNext` is 0x0001 and `nopSlot` and `stallReq` are 0.
- R2: A word that decodes to none of the flow instructions below gives `pcNext` = PC+1, with `stallReq`, `stackPush` and `stackPop` all 0.
- R3: A word whose bits [15:13] are 110 is a branch. `pcNext` = {pcLatch[7:5], word[12:0]} and `stallReq` is 1.
- R4: A word whose bits [15:13] are 111 is a call. It has the same target as R3, asserts `stallReq` and `stackPush`, and saves PC+1 on the return stack.
- R5: A word whose bits [15:8] are 0xB7 is a long call. `pcNext` = {pcLatch, word[7:0]}, and `stallReq` and `stackPush` are asserted, saving PC+1.
- R6: Three skip instructions are decoded: 0x33 in bits [15:8] skips when `fileZero` is 1; 10011 in bits [15:11] skips when `fileBit` is 0; 10010 in bits [15:11] skips when `fileBit` is 1. When its condition is false, a skip takes one cycle: `pcNext` = PC+1 and `stallReq` is 0.
- R7: When its condition is true, a skip asserts `stallReq` with `pcNext` = PC+1. In the next cycle `nopSlot` is 1, the word present is ignored (even if it is a branch or a call), and `pcNext` advances by one more.
- R8: After a branch, a call or a return, the next cycle is a no-operation slot. `nopSlot` is 1, the word present is ignored, and `pcNext` stays at the target.
- R9: The word 0x0002 returns, and the word 0x0005 returns from interrupt. Each asserts `stallReq` and `stackPop` and sets `pcNext` to the most recently saved address. Only 0x0005 pulses `clearIntDis`.
- R10: A word whose bits [15:8] are 0xB6 returns like R9. It also pulses `litLoad`, with `litValue` = word[7:0], and does not pulse `clearIntDis`.
- R11: The return stack is last-in first-out and 16 entries deep. Its pointer wraps: a 17th push overwrites the oldest entry, and popping past empty wraps back to the top.
- R12: A reset that arrives during a pending no-operation slot cancels the slot. The first word after reset executes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrWord | input | 16 | Instruction word in the execute stage |
| fileZero | input | 1 | Tested file register is zero |
| fileBit | input | 1 | Selected bit of the tested file register |
| pcLatch | input | 8 | High-address latch supplying upper PC bits |
| pcNext | output | 16 | Program counter for the next cycle |
| stallReq | output | 1 | Current instruction takes two cycles |
| nopSlot | output | 1 | Current word is squashed into a no-operation |
| stackPush | output | 1 | Return address pushed this cycle |
| stackPop | output | 1 | Return address popped this cycle |
| clearIntDis | output | 1 | Clear the global interrupt-disable bit |
| litLoad | output | 1 | Load `litValue` into the working register |
| litValue | output | 8 | Literal carried by a literal return |

## Verification
Some rules are checked by assertions on every cycle. Every stall is followed by exactly one no-operation slot. A slot never starts another two-cycle instruction, never pushes and never pops. Push and pop never happen together, and the interrupt-enable clear only comes with a pop. The stack pointer moves by exactly one on each push and each pop, and the PC holds still during a hold slot. Other behaviour needs the bench's scenarios: the exact target addresses built from the latch, the values that come back in LIFO order, a 17-deep overflow with underflow wrap, skips with true and false conditions, and a reset that cancels a pending slot.

// File: rtl/flowPkg.sv
package flowPkg;

  typedef enum logic [2:0] {
    SEL_INC,
    SEL_HOLD,
    SEL_SHORT,
    SEL_LONG,
    SEL_STACK
  } pcSel_e;

  typedef struct packed {
    pcSel_e sel;
    logic   push;
    logic   pop;
  } flowStrobe_t;

endpackage

// File: rtl/flowCtrl.sv
module flowCtrl
  import flowPkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               fileZero,
  input  logic               fileBit,
  output flowStrobe_t        strobe,
  output logic               stallReq,
  output logic               nopSlot,
  output logic               clearIntDis,
  output logic               litLoad
);

  localparam logic [2:0]         OP_BRANCH  = 3'b110;
  localparam logic [2:0]         OP_CALL    = 3'b111;
  localparam logic [7:0]         OP_LCALL   = 8'hB7;
  localparam logic [7:0]         OP_RETLIT  = 8'hB6;
  localparam logic [7:0]         OP_TSTZ    = 8'h33;
  localparam logic [4:0]         OP_SKPCLR  = 5'b10011;
  localparam logic [4:0]         OP_SKPSET  = 5'b10010;
  localparam logic [INSTR_W-1:0] W_RETURN   = INSTR_W'(16'h0002);
  localparam logic [INSTR_W-1:0] W_RETINT   = INSTR_W'(16'h0005);

  logic slotNop, slotAdv, skipTaken;

  always_comb begin
    strobe      = '{sel: SEL_INC, push: 1'b0, pop: 1'b0};
    stallReq    = 1'b0;
    skipTaken   = 1'b0;
    clearIntDis = 1'b0;
    litLoad     = 1'b0;
    if (slotNop) begin
      strobe.sel = slotAdv ? SEL_INC : SEL_HOLD;
    end else begin
      if (instrWord[INSTR_W-1 -: 3] == OP_BRANCH) begin
        strobe.sel = SEL_SHORT;
        stallReq   = 1'b1;
      end else if (instrWord[INSTR_W-1 -: 3] == OP_CALL) begin
        strobe.sel  = SEL_SHORT;
        strobe.push = 1'b1;
        stallReq    = 1'b1;
      end else if (instrWord[INSTR_W-1 -: 8] == OP_LCALL) begin
        strobe.sel  = SEL_LONG;
        strobe.push = 1'b1;
        stallReq    = 1'b1;
      end else if (instrWord[INSTR_W-1 -: 8] == OP_RETLIT) begin
        strobe.sel = SEL_STACK;
        strobe.pop = 1'b1;
        stallReq   = 1'b1;
        litLoad    = 1'b1;
      end else if (instrWord == W_RETURN || instrWord == W_RETINT) begin
        strobe.sel  = SEL_STACK;
        strobe.pop  = 1'b1;
        stallReq    = 1'b1;
        clearIntDis = (instrWord == W_RETINT);
      end else if (instrWord[INSTR_W-1 -: 8] == OP_TSTZ) begin
        skipTaken = fileZero;
      end else if (instrWord[INSTR_W-1 -: 5] == OP_SKPCLR) begin
        skipTaken = !fileBit;
      end else if (instrWord[INSTR_W-1 -: 5] == OP_SKPSET) begin
        skipTaken = fileBit;
      end
      if (skipTaken) stallReq = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotNop <= 1'b0;
      slotAdv <= 1'b0;
    end else begin
      slotNop <= stallReq;
      slotAdv <= skipTaken;
    end
  end

  assign nopSlot = slotNop;

  AST_SLOT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    stallReq |=> nopSlot); // R8
  AST_SLOT_INERT: assert property (@(posedge clk) disable iff (!rstN)
    nopSlot |-> !stallReq && !strobe.push && !strobe.pop); // R7
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.push && strobe.pop)); // R11
  AST_INTCLR_ON_POP: assert property (@(posedge clk) disable iff (!rstN)
    clearIntDis |-> strobe.pop && !litLoad); // R9

endmodule

// File: rtl/flowPath.sv
module flowPath
  import flowPkg::*;
#(
  parameter int PC_W        = 16,
  parameter int INSTR_W     = 16,
  parameter int SHORT_W     = 13,
  parameter int LATCH_W     = 8,
  parameter int STACK_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  flowStrobe_t        strobe,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [LATCH_W-1:0] pcLatch,
  output logic [PC_W-1:0]    pcNext
);

  localparam int SP_W  = $clog2(STACK_DEPTH);
  localparam int HI_W  = PC_W - SHORT_W;
  localparam int LIT_W = PC_W - LATCH_W;

  logic [PC_W-1:0] pc, pcInc, shortTgt, longTgt, popAddr;
  logic [SP_W-1:0] sp, spDec;
  logic [PC_W-1:0] stackMem [STACK_DEPTH];

  assign pcInc    = pc + 1'b1;
  assign spDec    = sp - 1'b1;
  assign popAddr  = stackMem[spDec];
  assign shortTgt = {pcLatch[LATCH_W-1 -: HI_W], instrWord[SHORT_W-1:0]};
  assign longTgt  = {pcLatch, instrWord[LIT_W-1:0]};

  always_comb begin
    case (strobe.sel)
      SEL_HOLD:  pcNext = pc;
      SEL_SHORT: pcNext = shortTgt;
      SEL_LONG:  pcNext = longTgt;
      SEL_STACK: pcNext = popAddr;
      default:   pcNext = pcInc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= '0;
      sp <= '0;
    end else begin
      pc <= pcNext;
      if (strobe.push)     sp <= sp + 1'b1;
      else if (strobe.pop) sp <= spDec;
    end
  end

  always_ff @(posedge clk) begin
    if (rstN && strobe.push) stackMem[sp] <= pcInc;
  end

  AST_SP_PUSH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> sp == SP_W'($past(sp) + 1'b1)); // R11
  AST_SP_POP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |=> sp == SP_W'($past(sp) - 1'b1)); // R11
  AST_HOLD_KEEPS_PC: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sel == SEL_HOLD |=> $stable(pc)); // R8

endmodule

// File: rtl/flowSeq.sv
module flowSeq
  import flowPkg::*;
#(
  parameter int PC_W        = 16,
  parameter int INSTR_W     = 16,
  parameter int SHORT_W     = 13,
  parameter int LATCH_W     = 8,
  parameter int STACK_DEPTH = 16,
  localparam int LIT_W      = PC_W - LATCH_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               fileZero,
  input  logic               fileBit,
  input  logic [LATCH_W-1:0] pcLatch,
  output logic [PC_W-1:0]    pcNext,
  output logic               stallReq,
  output logic               nopSlot,
  output logic               stackPush,
  output logic               stackPop,
  output logic               clearIntDis,
  output logic               litLoad,
  output logic [LIT_W-1:0]   litValue
);

  flowStrobe_t strobe;

  flowCtrl #(.INSTR_W(INSTR_W)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .instrWord   (instrWord),
    .fileZero    (fileZero),
    .fileBit     (fileBit),
    .strobe      (strobe),
    .stallReq    (stallReq),
    .nopSlot     (nopSlot),
    .clearIntDis (clearIntDis),
    .litLoad     (litLoad)
  );

  flowPath #(
    .PC_W        (PC_W),
    .INSTR_W     (INSTR_W),
    .SHORT_W     (SHORT_W),
    .LATCH_W     (LATCH_W),
    .STACK_DEPTH (STACK_DEPTH)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .instrWord (instrWord),
    .pcLatch   (pcLatch),
    .pcNext    (pcNext)
  );

  assign stackPush = strobe.push;
  assign stackPop  = strobe.pop;
  assign litValue  = instrWord[LIT_W-1:0];

endmodule

// File: tb/sim_flowSeq.sv
module sim_flowSeq;

  typedef struct packed {
    logic [23:0] tag;
    logic [15:0] instr;
    logic        fz;
    logic        fb;
    logic [7:0]  latch;
    logic [15:0] expNext;
    logic        expStall;
    logic        expNop;
    logic        expPush;
    logic        expPop;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    {"R3 ", 16'hC123, 1'b0, 1'b0, 8'h20, 16'h2123, 1'b1, 1'b0, 1'b0, 1'b0},
    {"R8 ", 16'hC555, 1'b0, 1'b0, 8'h20, 16'h2123, 1'b0, 1'b1, 1'b0, 1'b0},
    {"R4 ", 16'hE050, 1'b0, 1'b0, 8'h40, 16'h4050, 1'b1, 1'b0, 1'b1, 1'b0},
    {"R8 ", 16'h0000, 1'b0, 1'b0, 8'h40, 16'h4050, 1'b0, 1'b1, 1'b0, 1'b0},
    {"R6 ", 16'h3311, 1'b0, 1'b0, 8'h20, 16'h4051, 1'b0, 1'b0, 1'b0, 1'b0},
    {"R7 ", 16'h3311, 1'b1, 1'b0, 8'h20, 16'h4052, 1'b1, 1'b0, 1'b0, 1'b0},
    {"R7 ", 16'hE000, 1'b0, 1'b0, 8'h20, 16'h4053, 1'b0, 1'b1, 1'b0, 1'b0},
    {"R6 ", 16'h9A05, 1'b0, 1'b1, 8'h20, 16'h4054, 1'b0, 1'b0, 1'b0, 1'b0},
    {"R7 ", 16'h9A05, 1'b0, 1'b0, 8'h20, 16'h4055, 1'b1, 1'b0, 1'b0, 1'b0},
    {"R7 ", 16'h0000, 1'b0, 1'b0, 8'h20, 16'h4056, 1'b0, 1'b1, 1'b0, 1'b0},
    {"R6 ", 16'h9205, 1'b0, 1'b0, 8'h20, 16'h4057, 1'b0, 1'b0, 1'b0, 1'b0},
    {"R7 ", 16'h9205, 1'b0, 1'b1, 8'h20, 16'h4058, 1'b1, 1'b0, 1'b0, 1'b0},
    {"R7 ", 16'hC000, 1'b0, 1'b0, 8'h20, 16'h4059, 1'b0, 1'b1, 1'b0, 1'b0},
    {"R5 ", 16'hB734, 1'b0, 1'b0, 8'h7A, 16'h7A34, 1'b1, 1'b0, 1'b1, 1'b0},
    {"R8 ", 16'h0000, 1'b0, 1'b0, 8'h20, 16'h7A34, 1'b0, 1'b1, 1'b0, 1'b0},
    {"R9 ", 16'h0002, 1'b0, 1'b0, 8'h20, 16'h405A, 1'b1, 1'b0, 1'b0, 1'b1},
    {"R8 ", 16'h0000, 1'b0, 1'b0, 8'h20, 16'h405A, 1'b0, 1'b1, 1'b0, 1'b0},
    {"R10", 16'hB699, 1'b0, 1'b0, 8'h20, 16'h2124, 1'b1, 1'b0, 1'b0, 1'b1},
    {"R8 ", 16'h0000, 1'b0, 1'b0, 8'h20, 16'h2124, 1'b0, 1'b1, 1'b0, 1'b0},
    {"R2 ", 16'h0000, 1'b0, 1'b0, 8'h20, 16'h2125, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] instrWord = '0;
  logic        fileZero = 1'b0;
  logic        fileBit = 1'b0;
  logic [7:0]  pcLatch = '0;
  logic [15:0] pcNext;
  logic        stallReq, nopSlot, stackPush, stackPop, clearIntDis, litLoad;
  logic [7:0]  litValue;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  flowSeq u0 (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .fileZero(fileZero),
    .fileBit(fileBit), .pcLatch(pcLatch), .pcNext(pcNext), .stallReq(stallReq),
    .nopSlot(nopSlot), .stackPush(stackPush), .stackPop(stackPop),
    .clearIntDis(clearIntDis), .litLoad(litLoad), .litValue(litValue)
  );

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      nChecks = nChecks + 1;
      nFails  = nFails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 20000", cycles);
      finishRun();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks = nChecks + 1;
    if (act !== exp) begin
      nFails = nFails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] w, input logic fz, input logic fb, input logic [7:0] lt);
    @(negedge clk);
    instrWord = w;
    fileZero  = fz;
    fileBit   = fb;
    pcLatch   = lt;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    instrWord = '0;
    fileZero = 1'b0;
    fileBit = 1'b0;
    pcLatch = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  initial begin
    logic [15:0] popVal;
    doReset();
    // R1: reset state, non-flow word at PC 0
    chk("R1", {pcNext, 13'd0, stallReq, nopSlot, stackPush}, {16'h0001, 16'h0000});

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].instr, VECS[i].fz, VECS[i].fb, VECS[i].latch);
      chk(string'(VECS[i].tag),
          {12'd0, pcNext, stallReq, nopSlot, stackPush, stackPop},
          {12'd0, VECS[i].expNext, VECS[i].expStall, VECS[i].expNop,
           VECS[i].expPush, VECS[i].expPop});
    end

    // R9: interrupt return clears the disable bit and returns
    step(16'hE200, 1'b0, 1'b0, 8'h00);
    chk("R4", {pcNext, 14'd0, stackPush, stallReq}, {16'h0200, 16'h0003});
    step(16'h0000, 1'b0, 1'b0, 8'h00);
    step(16'h0005, 1'b0, 1'b0, 8'h00);
    chk("R9", {pcNext, 13'd0, clearIntDis, stackPop, litLoad}, {16'h2126, 16'h0006});
    step(16'h0000, 1'b0, 1'b0, 8'h00);
    chk("R9", {31'd0, clearIntDis}, 32'd0);

    // R10: literal return loads literal, no interrupt-enable clear
    step(16'hE300, 1'b0, 1'b0, 8'h00);
    step(16'h0000, 1'b0, 1'b0, 8'h00);
    step(16'hB6A5, 1'b0, 1'b0, 8'h00);
    chk("R10", {pcNext, litValue, 6'd0, litLoad, clearIntDis}, {16'h2127, 8'hA5, 8'h02});

    // R11: 17 pushes wrap over entry 0, 17 pops wrap past empty
    doReset();
    for (int i = 0; i < 17; i++) begin
      step(16'hE000 | 16'((i + 1) * 16), 1'b0, 1'b0, 8'h00);
      if (i == 16) chk("R11", {16'd0, pcNext}, {16'd0, 16'd272});
      step(16'h0000, 1'b0, 1'b0, 8'h00);
    end
    for (int k = 1; k <= 17; k++) begin
      step(16'h0002, 1'b0, 1'b0, 8'h00);
      popVal = pcNext;
      if (k == 1)  chk("R11", {16'd0, popVal}, {16'd0, 16'd257});
      if (k == 2)  chk("R11", {16'd0, popVal}, {16'd0, 16'd241});
      if (k == 16) chk("R11", {16'd0, popVal}, {16'd0, 16'd17});
      if (k == 17) chk("R11", {16'd0, popVal}, {16'd0, 16'd257});
      step(16'h0000, 1'b0, 1'b0, 8'h00);
    end

    // R12: reset during a pending slot cancels it
    step(16'hC010, 1'b0, 1'b0, 8'h00);
    chk("R12", {31'd0, stallReq}, 32'd1);
    doReset();
    step(16'hC040, 1'b0, 1'b0, 8'h00);
    chk("R12", {pcNext, 14'd0, nopSlot, stallReq}, {16'h0040, 16'h0001});

    finishRun();
  end

endmodule